// File: doc/BRIEF.md
# UART Interrupt Prioritizer

This block gathers every interrupt cause of a single UART channel and reduces them to one 4-bit status code that names the most urgent cause still waiting for service, together with an active-high interrupt request line. It latches sticky causes: line errors, modem-status changes and transmit readiness. It compares the receive FIFO fill against its trigger threshold. It also owns the receive idle timer, which counts bit-clock ticks while received data sits unread.

Each cause is gated by its own enable bit before ranking. A cause that is masked or outranked stays latched and shows up as soon as it becomes the highest enabled one. Each cause is cleared by its own register access strobe, as a register front end would issue them. The status code and the request line are both registered, so they update one clock after the stimulus that changes them.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is held, and after it with no cause pending, the status code is 0001 and irq_o is 0.
- R2: Causes are ranked highest first as line status (code 0110), receive timeout (1100), receive data ready (0100), transmit ready (0010), modem status (0000). Only the top enabled cause is reported, and a lower cause appears once every higher one is cleared.
- R3: A high on any bit of lsr_err_i[3:0] latches the line-status cause, and rd_lsr_i clears it. When a set and a clear arrive in the same cycle, the set wins.
- R4: Receive data ready is reported while rx_level_i is nonzero and at or above rx_trig_i. It drops as soon as the level falls below the trigger.
- R5: The receive timeout fires after (4 × char_bits_i + 12) bit_tick_i pulses counted while rx_level_i is nonzero. rx_char_i and rd_rhr_i restart the count, and the count is held at zero while the FIFO is empty. rd_rhr_i clears a fired timeout.
- R6: Transmit ready latches on a rising edge of (tx_empty_i OR tx_trig_i). It is cleared by wr_thr_i, or by rd_isr_i only when the code currently presented is 0010. It does not re-arm while that level stays high.
- R7: A high on any bit of msr_delta_i[3:0] latches the modem-status cause, and rd_msr_i clears it.
- R8: Enables are read from ier_i: bit 0 gates receive data ready and receive timeout, bit 1 gates transmit ready, bit 2 gates line status and bit 3 gates modem status. Bits 7:4 have no effect. A masked cause stays latched.
- R9: irq_o is the inverse of status bit 0 and is updated in the same clock edge as the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_i | input | 8 | Per-cause enable bits |
| lsr_err_i | input | 4 | Line error flags (overrun, parity, framing, break) |
| msr_delta_i | input | 4 | Modem-status change flags |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| rx_trig_i | input | LVL_W | Receive FIFO trigger threshold |
| rx_char_i | input | 1 | Pulse when a character enters the receive FIFO |
| bit_tick_i | input | 1 | One pulse per serial bit time |
| char_bits_i | input | CHB_W | Bits per character frame |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_trig_i | input | 1 | Transmit FIFO at its trigger level |
| rd_isr_i | input | 1 | Status register read strobe |
| rd_lsr_i | input | 1 | Line status register read strobe |
| rd_msr_i | input | 1 | Modem status register read strobe |
| rd_rhr_i | input | 1 | Receive holding register read strobe |
| wr_thr_i | input | 1 | Transmit holding register write strobe |
| code_o | output | 4 | Status code of the top enabled cause |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Every result is due exactly one clock edge after its stimulus. Sticky latches, level compares, enables and the priority encoder all feed the registered code through next-state logic. The receive timeout is due on the edge of its (4 × bits + 12)th counted tick. The bench drives inputs on the falling edge and pushes the expected code into a queue at that moment. A monitor pops it 1 ns after the next rising edge and compares code_o and irq_o there. For timeout windows, the bench checks the tick one before the firing tick as well as the firing tick itself, which pins down the exact edge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [3:0] {
        CODE_MSR  = 4'b0000,
        CODE_NONE = 4'b0001,
        CODE_TXR  = 4'b0010,
        CODE_RDR  = 4'b0100,
        CODE_LSR  = 4'b0110,
        CODE_RTO  = 4'b1100
    } irq_code_e;

    // Packed with the highest priority cause in the most significant bit.
    typedef struct packed {
        logic lsr;
        logic rto;
        logic rdr;
        logic txr;
        logic msr;
    } irq_vec_t;

    localparam int NUM_SRC = $bits(irq_vec_t);

    // Code reported for a cause, indexed by its bit position in irq_vec_t.
    function automatic logic [3:0] src_code(input int idx);
        case (idx)
            4:       return CODE_LSR;
            3:       return CODE_RTO;
            2:       return CODE_RDR;
            1:       return CODE_TXR;
            default: return CODE_MSR;
        endcase
    endfunction

    // Apply the enable register: bit0 receive, bit1 transmit, bit2 line, bit3 modem.
    function automatic irq_vec_t mask_src(input irq_vec_t v, input logic [7:0] en);
        irq_vec_t m;
        m.lsr = v.lsr & en[2];
        m.rto = v.rto & en[0];
        m.rdr = v.rdr & en[0];
        m.txr = v.txr & en[1];
        m.msr = v.msr & en[3];
        return m;
    endfunction

endpackage

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
    parameter int CHB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             restart,
    input  logic             tick,
    input  logic [CHB_W-1:0] char_bits,
    output logic             fire
);
    localparam int MAX_LIM = 4 * ((1 << CHB_W) - 1) + 12;
    localparam int CNT_W   = $clog2(MAX_LIM + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'({char_bits, 2'b00}) + CNT_W'(12);
    assign fire  = active && !restart && tick && (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !active || restart) begin
            cnt_q <= '0;
        end else if (tick && cnt_q < limit) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R5: counter is held at zero whenever the receive FIFO is empty
    p_hold_empty_r5: assert property (@(posedge clk) disable iff (rst)
        !active |=> cnt_q == '0);

endmodule

// File: rtl/uart_irq_sources.sv
module uart_irq_sources
    import uart_irq_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       lsr_err,
    input  logic [3:0]       msr_delta,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_trig,
    input  logic             rto_fire,
    input  logic             tx_empty,
    input  logic             tx_trig,
    input  logic             txr_ack,
    input  logic             rd_lsr,
    input  logic             rd_msr,
    input  logic             rd_rhr,
    input  logic             wr_thr,
    output irq_vec_t         pend_n,
    output irq_vec_t         pend_q
);
    logic tx_lvl, tx_prev_q, tx_rise;

    assign tx_lvl  = tx_empty | tx_trig;
    assign tx_rise = tx_lvl & ~tx_prev_q;

    always_comb begin
        pend_n.lsr = (pend_q.lsr & ~rd_lsr) | (|lsr_err);
        pend_n.msr = (pend_q.msr & ~rd_msr) | (|msr_delta);
        pend_n.rto = (pend_q.rto & ~rd_rhr) | rto_fire;
        pend_n.txr = (pend_q.txr & ~(wr_thr | txr_ack)) | tx_rise;
        pend_n.rdr = (rx_level != '0) && (rx_level >= rx_trig);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            tx_prev_q <= 1'b0;
        end else begin
            pend_q    <= pend_n;
            tx_prev_q <= tx_lvl;
        end
    end

    // R3: a read with no fresh error leaves the line cause cleared
    p_lsr_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_lsr && lsr_err == '0) |=> !pend_q.lsr);

    // R7: a read with no fresh change leaves the modem cause cleared
    p_msr_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_msr && msr_delta == '0) |=> !pend_q.msr);

    // R5: a holding register read always clears the timeout
    p_rto_clear_r5: assert property (@(posedge clk) disable iff (rst)
        rd_rhr |=> !pend_q.rto);

    // R6: a steady transmit level never re-raises a cleared cause
    p_tx_rearm_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_thr && !tx_rise) |=> !pend_q.txr);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic [3:0]   code
);
    for (genvar i = 0; i < N; i++) begin : g_grant
        if (i == N - 1) begin : g_top
            assign grant[i] = req[i];
        end else begin : g_low
            assign grant[i] = req[i] & ~(|req[N-1:i+1]);
        end
    end

    always_comb begin
        code = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) code = code | src_code(i);
        end
        if (req == '0) code = CODE_NONE;
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int LVL_W = 5,
    parameter int CHB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       ier_i,
    input  logic [3:0]       lsr_err_i,
    input  logic [3:0]       msr_delta_i,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic [LVL_W-1:0] rx_trig_i,
    input  logic             rx_char_i,
    input  logic             bit_tick_i,
    input  logic [CHB_W-1:0] char_bits_i,
    input  logic             tx_empty_i,
    input  logic             tx_trig_i,
    input  logic             rd_isr_i,
    input  logic             rd_lsr_i,
    input  logic             rd_msr_i,
    input  logic             rd_rhr_i,
    input  logic             wr_thr_i,
    output logic [3:0]       code_o,
    output logic             irq_o
);
    irq_vec_t           pend_n, pend_q, masked;
    logic [NUM_SRC-1:0] grant;
    logic [3:0]         code_n;
    logic               rto_fire;
    logic               txr_ack;

    assign txr_ack = rd_isr_i && (code_o == CODE_TXR);

    uart_irq_timeout #(.CHB_W(CHB_W)) u_timeout (
        .clk       (clk),
        .rst       (rst),
        .active    (rx_level_i != '0),
        .restart   (rx_char_i | rd_rhr_i),
        .tick      (bit_tick_i),
        .char_bits (char_bits_i),
        .fire      (rto_fire)
    );

    uart_irq_sources #(.LVL_W(LVL_W)) u_sources (
        .clk       (clk),
        .rst       (rst),
        .lsr_err   (lsr_err_i),
        .msr_delta (msr_delta_i),
        .rx_level  (rx_level_i),
        .rx_trig   (rx_trig_i),
        .rto_fire  (rto_fire),
        .tx_empty  (tx_empty_i),
        .tx_trig   (tx_trig_i),
        .txr_ack   (txr_ack),
        .rd_lsr    (rd_lsr_i),
        .rd_msr    (rd_msr_i),
        .rd_rhr    (rd_rhr_i),
        .wr_thr    (wr_thr_i),
        .pend_n    (pend_n),
        .pend_q    (pend_q)
    );

    assign masked = mask_src(pend_n, ier_i);

    uart_irq_prio #(.N(NUM_SRC)) u_prio (
        .req   (masked),
        .grant (grant),
        .code  (code_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            code_o <= CODE_NONE;
            irq_o  <= 1'b0;
        end else begin
            code_o <= code_n;
            irq_o  <= ~code_n[0];
        end
    end

    // R2: the top code is shown only while its latched cause is held
    p_lsr_shown_r2: assert property (@(posedge clk) disable iff (rst)
        (code_o == CODE_LSR) |-> pend_q.lsr);

    // R6: a transmit code read is followed by no transmit code unless re-armed
    p_tx_ack_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_isr_i && code_o == CODE_TXR && !tx_empty_i && !tx_trig_i) |=> code_o != CODE_TXR);

endmodule

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;
    localparam int LVL_W = 5;
    localparam int CHB_W = 4;

    logic             clk = 1'b0;
    logic             rst;
    logic [7:0]       ier_i;
    logic [3:0]       lsr_err_i, msr_delta_i;
    logic [LVL_W-1:0] rx_level_i, rx_trig_i;
    logic             rx_char_i, bit_tick_i;
    logic [CHB_W-1:0] char_bits_i;
    logic             tx_empty_i, tx_trig_i;
    logic             rd_isr_i, rd_lsr_i, rd_msr_i, rd_rhr_i, wr_thr_i;
    logic [3:0]       code_o;
    logic             irq_o;

    localparam logic [3:0] C_LSR = 4'b0110, C_RTO = 4'b1100, C_RDR = 4'b0100,
                           C_TXR = 4'b0010, C_MSR = 4'b0000, C_NONE = 4'b0001;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [3:0] exp_q[$];
    string      tag_q[$];
    logic [3:0] e;
    string      t;

    always #2.5 clk = ~clk;

    uart_irq_ctrl #(.LVL_W(LVL_W), .CHB_W(CHB_W)) dut (
        .clk(clk), .rst(rst), .ier_i(ier_i), .lsr_err_i(lsr_err_i),
        .msr_delta_i(msr_delta_i), .rx_level_i(rx_level_i), .rx_trig_i(rx_trig_i),
        .rx_char_i(rx_char_i), .bit_tick_i(bit_tick_i), .char_bits_i(char_bits_i),
        .tx_empty_i(tx_empty_i), .tx_trig_i(tx_trig_i), .rd_isr_i(rd_isr_i),
        .rd_lsr_i(rd_lsr_i), .rd_msr_i(rd_msr_i), .rd_rhr_i(rd_rhr_i),
        .wr_thr_i(wr_thr_i), .code_o(code_o), .irq_o(irq_o)
    );

    // Monitor: compare one expected item per rising edge, away from the edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (code_o !== e || irq_o !== ~e[0]) begin
                fails++;
                $display("FAIL %s: code=%b irq=%b expected code=%b irq=%b",
                         t, code_o, irq_o, e, ~e[0]);
            end
        end
    end

    // Driver: inputs already set at the falling edge; push expectation, run one cycle.
    task automatic step(input bit chk, input logic [3:0] exp, input string tag);
        if (chk) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(posedge clk);
        @(negedge clk);
        lsr_err_i = '0; msr_delta_i = '0; rx_char_i = 0; bit_tick_i = 0;
        rd_isr_i = 0; rd_lsr_i = 0; rd_msr_i = 0; rd_rhr_i = 0; wr_thr_i = 0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; ier_i = 8'h0F; lsr_err_i = '0; msr_delta_i = '0;
        rx_level_i = '0; rx_trig_i = 5'd4; rx_char_i = 0; bit_tick_i = 0;
        char_bits_i = 4'd10; tx_empty_i = 0; tx_trig_i = 0;
        rd_isr_i = 0; rd_lsr_i = 0; rd_msr_i = 0; rd_rhr_i = 0; wr_thr_i = 0;
        @(negedge clk);
        step(1, C_NONE, "R1 reset");
        step(0, C_NONE, "");
        rst = 0;
        step(1, C_NONE, "R1 idle after reset");

        // Modem status, lowest priority
        msr_delta_i = 4'b0100; step(1, C_MSR, "R7 modem set");
        step(1, C_MSR, "R7 modem held");
        // Transmit outranks modem
        tx_empty_i = 1; step(1, C_TXR, "R2 tx over modem");
        rd_isr_i = 1;   step(1, C_MSR, "R6 isr read clears tx, modem queued");
        step(1, C_MSR, "R6 no rearm on steady empty");
        rd_msr_i = 1;   step(1, C_NONE, "R7 modem read clears");
        tx_empty_i = 0; step(1, C_NONE, "R6 tx level low");
        tx_trig_i = 1;  step(1, C_TXR, "R6 rearm on trigger edge");
        wr_thr_i = 1;   step(1, C_NONE, "R6 thr write clears");
        tx_trig_i = 0;  step(0, C_NONE, "");

        // Line status outranks transmit; isr read of other code keeps tx
        tx_empty_i = 1; lsr_err_i = 4'b0001; step(1, C_LSR, "R3 line set over tx");
        rd_isr_i = 1;   step(1, C_LSR, "R6 isr read while line shown");
        rd_lsr_i = 1;   step(1, C_TXR, "R2 tx queued under line");
        wr_thr_i = 1;   step(1, C_NONE, "R6 thr write clears");
        tx_empty_i = 0; step(0, C_NONE, "");

        // Receive data ready against trigger
        rx_level_i = 5'd3; step(1, C_NONE, "R4 below trigger");
        rx_level_i = 5'd4; step(1, C_RDR, "R4 at trigger");
        rx_level_i = 5'd3; step(1, C_NONE, "R4 back below");
        rx_level_i = 5'd4; step(1, C_RDR, "R4 at trigger again");

        // Receive timeout: 4*10+12 = 52 ticks
        rx_char_i = 1; step(1, C_RDR, "R5 restart on char");
        for (int i = 0; i < 51; i++) begin
            bit_tick_i = 1; step(i == 50, C_RDR, "R5 tick 51 no timeout");
        end
        bit_tick_i = 1; step(1, C_RTO, "R5 timeout at tick 52");
        rd_rhr_i = 1;   step(1, C_RDR, "R5 rhr read clears timeout");
        rd_rhr_i = 1; rx_level_i = '0; step(1, C_NONE, "R4 empty fifo");
        for (int i = 0; i < 60; i++) begin
            bit_tick_i = 1; step(i == 59, C_NONE, "R5 no count while empty");
        end
        rx_level_i = 5'd1;
        for (int i = 0; i < 30; i++) begin
            bit_tick_i = 1; step(0, C_NONE, "");
        end
        rx_char_i = 1; step(1, C_NONE, "R5 char restarts count");
        for (int i = 0; i < 51; i++) begin
            bit_tick_i = 1; step(i == 50, C_NONE, "R5 restarted window tick 51");
        end
        bit_tick_i = 1; step(1, C_RTO, "R5 timeout after restart");
        rd_rhr_i = 1; rx_level_i = '0; step(1, C_NONE, "R5 rhr read clears");

        // Enables
        ier_i = 8'hF0; lsr_err_i = 4'b1000; step(1, C_NONE, "R8 reserved enables no effect");
        ier_i = 8'h04; step(1, C_LSR, "R8 masked line cause held");
        rd_lsr_i = 1;  step(1, C_NONE, "R3 line read clears");
        ier_i = 8'hFD; tx_trig_i = 1; step(1, C_NONE, "R8 tx masked");
        ier_i = 8'h0F; step(1, C_TXR, "R8 tx unmasked");
        wr_thr_i = 1;  step(1, C_NONE, "R6 clear");
        tx_trig_i = 0;

        // Set wins over clear
        lsr_err_i = 4'b0010; rd_lsr_i = 1; step(1, C_LSR, "R3 set beats clear");
        rd_lsr_i = 1; step(1, C_NONE, "R3 clear, R9 irq low");

        step(0, C_NONE, "");
        step(0, C_NONE, "");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule